// File: doc/BRIEF.md
# Cache Activity and Cycle-Cost Counter Bank

This block keeps the performance statistics of one cache. Single-cycle event strobes come from the cache controller: read hit, read miss, write hit, write miss, memory block fetch and memory block write-out. A slot index names the cache line that the event concerns. A static block-size selector sets the price of a memory transfer.

From these inputs the block keeps a set of saturating counters:

- hits and misses, in total and split by read and write;
- hits and misses for each slot;
- the number of memory updates;
- the accumulated cycle cost of the cache.

A parameter marks the cache as a data cache. An instruction cache takes no writes, so on an instruction cache all write and write-out strobes are ignored.

Cost accounting charges one cycle for every cache access, hit or miss, read or write. Each memory block transfer in either direction adds a burst price: ten cycles for the first word and two for each further word. Several strobes in the same clock are all charged in that one clock. A host reads the counters through an address-decoded 32-bit port with one cycle of latency. A synchronous clear zeroes all counters.

Top module: `cache_perf_counter`

## Requirements
- R1: After reset, and in the cycle after a clear, every counter reads 0. The clear takes precedence over any event strobe in the same cycle.
- R2: Each access strobe (read hit, read miss, write hit, write miss) adds 1 to the cycle counter.
- R3: Each memory transfer strobe (fetch or write-out) adds a cost to the cycle counter that depends on the block selector: 0 selects one word and costs 10; 1 selects two words and costs 12; 2 and 3 select four words and cost 16.
- R4: When several strobes are asserted in the same cycle, the cycle counter rises by the sum of all their costs in that one cycle, and every event counter counts each of them.
- R5: Read hits and read misses are counted at address 2 and address 3. The total hit count at address 0 includes read hits, and the total miss count at address 1 includes read misses.
- R6: With IS_DATA=1, write hits and write misses are counted at address 4 and address 5, and are also included in the totals at addresses 0 and 1. With IS_DATA=0, write-hit, write-miss and write-out strobes change no counter.
- R7: Slot s keeps its own hit count at address 8+2s and its own miss count at address 9+2s. Each of these counts hits or misses of both kinds for the slot given by the slot index input.
- R8: The memory update counter at address 6 increments once for each write-out strobe.
- R9: Every counter stops at 2^CNT_W-1 and does not wrap.
- R10: A value is read by presenting an address on rd_addr. rd_data shows the counter at that address, zero-extended, one clock after the address is presented. The cycle counter is at address 7. Addresses at or above 8+2*SLOTS read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| ev_rd_hit | input | 1 | Read hit strobe |
| ev_rd_miss | input | 1 | Read miss strobe |
| ev_wr_hit | input | 1 | Write hit strobe |
| ev_wr_miss | input | 1 | Write miss strobe |
| ev_mem_rd | input | 1 | Memory block fetch strobe |
| ev_mem_wr | input | 1 | Memory block write-out strobe |
| ev_slot | input | SLOT_W | Slot index of the access |
| blk_sel | input | 2 | Block size selector (0: 1 word, 1: 2 words, 2/3: 4 words) |
| rd_addr | input | AW | Counter read address |
| rd_data | output | 32 | Counter read data, registered |

## Verification
A strobe held for one clock is visible in the counters after the next rising edge. A read presented on rd_addr is visible on rd_data after the following edge. Reading a counter therefore takes two edges from the event: one to update the counter and one to register the read data. The bench drives on falling edges and samples on the next falling edge after an address change, so each sample sees exactly one registered step. The expected counter set is kept in the bench as a saturating model per instance. After each scenario, every address of both the data-cache and instruction-cache instances is swept and compared.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
   // number of global (non-slot) counters and their read addresses
   localparam int unsigned NGLOB   = 8;
   localparam int unsigned A_HIT   = 0;
   localparam int unsigned A_MISS  = 1;
   localparam int unsigned A_RDH   = 2;
   localparam int unsigned A_RDM   = 3;
   localparam int unsigned A_WRH   = 4;
   localparam int unsigned A_WRM   = 5;
   localparam int unsigned A_UPD   = 6;
   localparam int unsigned A_CYC   = 7;
   localparam int unsigned INC_W   = 6;   // max per-cycle increment 4+2*16 = 36

   localparam int unsigned BURST_FIRST = 10;
   localparam int unsigned BURST_NEXT  = 2;

   function automatic logic [INC_W-1:0] xfer_cost(input logic [1:0] sel);
      int unsigned words;
      case (sel)
         2'd0:    words = 1;
         2'd1:    words = 2;
         default: words = 4;
      endcase
      return INC_W'(BURST_FIRST + BURST_NEXT * (words - 1));
   endfunction
endpackage

// File: rtl/cpc_sat_counter.sv
module cpc_sat_counter #(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned INC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [INC_W-1:0] inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

   if (CNT_W <= INC_W) begin : g_bad_width
      $error("cpc_sat_counter: CNT_W must exceed INC_W");
   end

   logic [CNT_W:0] sum;
   assign sum = {1'b0, cnt} + (CNT_W+1)'(inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clr)         cnt <= '0;
      else if (sum[CNT_W])  cnt <= MAX;
      else                  cnt <= sum[CNT_W-1:0];
   end

   // R1
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0);
   // R9
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && cnt == MAX) |=> cnt == MAX);
   // R9
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> cnt >= $past(cnt));
endmodule

// File: rtl/cpc_event_cost.sv
module cpc_event_cost
   import cpc_pkg::*;
#(
   parameter bit IS_DATA = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_rd_hit,
   input  logic             ev_rd_miss,
   input  logic             ev_wr_hit,
   input  logic             ev_wr_miss,
   input  logic             ev_mem_rd,
   input  logic             ev_mem_wr,
   input  logic [1:0]       blk_sel,
   output logic [INC_W-1:0] glob_inc [NGLOB],
   output logic [INC_W-1:0] slot_hit_inc,
   output logic [INC_W-1:0] slot_miss_inc
);
   logic wh, wm, mw;
   logic [INC_W-1:0] cost, acc, xfers;

   if (IS_DATA) begin : g_data
      assign wh = ev_wr_hit;
      assign wm = ev_wr_miss;
      assign mw = ev_mem_wr;
   end else begin : g_instr
      assign wh = 1'b0;
      assign wm = 1'b0;
      assign mw = 1'b0;
   end

   assign cost  = xfer_cost(blk_sel);
   assign acc   = INC_W'(ev_rd_hit) + INC_W'(ev_rd_miss) + INC_W'(wh) + INC_W'(wm);
   assign xfers = INC_W'(ev_mem_rd) + INC_W'(mw);

   always_comb begin
      glob_inc[A_HIT]  = INC_W'(ev_rd_hit) + INC_W'(wh);
      glob_inc[A_MISS] = INC_W'(ev_rd_miss) + INC_W'(wm);
      glob_inc[A_RDH]  = INC_W'(ev_rd_hit);
      glob_inc[A_RDM]  = INC_W'(ev_rd_miss);
      glob_inc[A_WRH]  = INC_W'(wh);
      glob_inc[A_WRM]  = INC_W'(wm);
      glob_inc[A_UPD]  = INC_W'(mw);
      glob_inc[A_CYC]  = acc + INC_W'(xfers * cost);
   end

   assign slot_hit_inc  = glob_inc[A_HIT];
   assign slot_miss_inc = glob_inc[A_MISS];

   // R3
   burst_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_mem_rd && !mw && !ev_rd_hit && !ev_rd_miss && !wh && !wm)
      |-> (glob_inc[A_CYC] == 6'd10 || glob_inc[A_CYC] == 6'd12 || glob_inc[A_CYC] == 6'd16));
   // R2
   access_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_mem_rd && !mw) |-> glob_inc[A_CYC] == glob_inc[A_HIT] + glob_inc[A_MISS]);
endmodule

// File: rtl/cache_perf_counter.sv
module cache_perf_counter
   import cpc_pkg::*;
#(
   parameter int unsigned SLOTS   = 8,
   parameter int unsigned CNT_W   = 32,
   parameter bit          IS_DATA = 1'b1,
   localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int unsigned NREG   = NGLOB + 2 * SLOTS,
   localparam int unsigned AW     = $clog2(NREG),
   localparam int unsigned RSPACE = 1 << AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ev_rd_hit,
   input  logic              ev_rd_miss,
   input  logic              ev_wr_hit,
   input  logic              ev_wr_miss,
   input  logic              ev_mem_rd,
   input  logic              ev_mem_wr,
   input  logic [SLOT_W-1:0] ev_slot,
   input  logic [1:0]        blk_sel,
   input  logic [AW-1:0]     rd_addr,
   output logic [31:0]       rd_data
);
   if (SLOTS < 1 || SLOTS > 256) begin : g_bad_slots
      $error("cache_perf_counter: SLOTS out of range");
   end
   if (CNT_W < 8 || CNT_W > 32) begin : g_bad_cnt
      $error("cache_perf_counter: CNT_W must be 8..32");
   end

   logic [INC_W-1:0] glob_inc [NGLOB];
   logic [INC_W-1:0] slot_hit_inc, slot_miss_inc;
   logic [CNT_W-1:0] cnt_all [RSPACE];

   cpc_event_cost #(.IS_DATA(IS_DATA)) i_cost (
      .clk(clk), .rst_n(rst_n),
      .ev_rd_hit(ev_rd_hit), .ev_rd_miss(ev_rd_miss),
      .ev_wr_hit(ev_wr_hit), .ev_wr_miss(ev_wr_miss),
      .ev_mem_rd(ev_mem_rd), .ev_mem_wr(ev_mem_wr),
      .blk_sel(blk_sel), .glob_inc(glob_inc),
      .slot_hit_inc(slot_hit_inc), .slot_miss_inc(slot_miss_inc)
   );

   for (genvar g = 0; g < NGLOB; g++) begin : g_glob
      cpc_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) i_cnt (
         .clk(clk), .rst_n(rst_n), .clr(clr),
         .inc(glob_inc[g]), .cnt(cnt_all[g])
      );
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic sel;
      assign sel = (ev_slot == SLOT_W'(s));
      cpc_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) i_hit (
         .clk(clk), .rst_n(rst_n), .clr(clr),
         .inc(sel ? slot_hit_inc : '0), .cnt(cnt_all[NGLOB + 2*s])
      );
      cpc_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) i_miss (
         .clk(clk), .rst_n(rst_n), .clr(clr),
         .inc(sel ? slot_miss_inc : '0), .cnt(cnt_all[NGLOB + 2*s + 1])
      );
   end

   for (genvar u = NREG; u < RSPACE; u++) begin : g_unused
      assign cnt_all[u] = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= 32'(cnt_all[rd_addr]);
   end

   // R10
   read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr == AW'(A_CYC) |=> rd_data == 32'($past(cnt_all[A_CYC])));

   if (!IS_DATA) begin : g_ro_chk
      // R6
      ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_all[A_WRH] == '0 && cnt_all[A_WRM] == '0 && cnt_all[A_UPD] == '0);
   end
endmodule

// File: tb/test_cache_perf_counter.sv
`timescale 1ns/1ps
module test_cache_perf_counter;
   localparam int SLOTS = 3;
   localparam int CNT_W = 8;
   localparam int NREG  = 8 + 2*SLOTS;   // 14
   localparam int AW    = 4;
   localparam int MAXV  = 255;

   logic clk = 1'b0;
   logic rst_n = 1'b0, clr = 1'b0;
   logic rh = 0, rm = 0, wh = 0, wm = 0, mr = 0, mw = 0;
   logic [1:0] slot = '0;
   logic [1:0] bsel = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0] rd_d, rd_i;

   int vectors = 0, errors = 0;
   int exp_d [16];
   int exp_i [16];

   always #4 clk = ~clk;

   cache_perf_counter #(.SLOTS(SLOTS), .CNT_W(CNT_W), .IS_DATA(1'b1)) i_cache_perf_counter (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .ev_rd_hit(rh), .ev_rd_miss(rm), .ev_wr_hit(wh), .ev_wr_miss(wm),
      .ev_mem_rd(mr), .ev_mem_wr(mw), .ev_slot(slot), .blk_sel(bsel),
      .rd_addr(rd_addr), .rd_data(rd_d));

   cache_perf_counter #(.SLOTS(SLOTS), .CNT_W(CNT_W), .IS_DATA(1'b0)) i_cache_perf_counter_ro (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .ev_rd_hit(rh), .ev_rd_miss(rm), .ev_wr_hit(wh), .ev_wr_miss(wm),
      .ev_mem_rd(mr), .ev_mem_wr(mw), .ev_slot(slot), .blk_sel(bsel),
      .rd_addr(rd_addr), .rd_data(rd_i));

   function automatic int sadd(int v, int inc);
      return (v + inc > MAXV) ? MAXV : v + inc;
   endfunction

   function automatic int cost_of(logic [1:0] s);
      return (s == 2'd0) ? 10 : (s == 2'd1) ? 12 : 16;
   endfunction

   task automatic model(ref int e [16], input bit d);
      int h  = rh + (d ? wh : 0);
      int m  = rm + (d ? wm : 0);
      int w  = d ? mw : 0;
      e[0] = sadd(e[0], h);
      e[1] = sadd(e[1], m);
      e[2] = sadd(e[2], rh);
      e[3] = sadd(e[3], rm);
      e[4] = sadd(e[4], d ? wh : 0);
      e[5] = sadd(e[5], d ? wm : 0);
      e[6] = sadd(e[6], w);
      e[7] = sadd(e[7], h + m + (mr + w) * cost_of(bsel));
      e[8 + 2*slot] = sadd(e[8 + 2*slot], h);
      e[9 + 2*slot] = sadd(e[9 + 2*slot], m);
   endtask

   task automatic pulse(input logic a, b, c, dd, e, f, input logic [1:0] s);
      @(negedge clk);
      rh = a; rm = b; wh = c; wm = dd; mr = e; mw = f; slot = s;
      model(exp_d, 1'b1);
      model(exp_i, 1'b0);
      @(negedge clk);
      rh = 0; rm = 0; wh = 0; wm = 0; mr = 0; mw = 0;
   endtask

   task automatic zero_model();
      for (int k = 0; k < 16; k++) begin
         exp_d[k] = 0;
         exp_i[k] = 0;
      end
   endtask

   task automatic check_all(input string tag);
      for (int a = 0; a < 16; a++) begin
         rd_addr = AW'(a);
         @(negedge clk);
         vectors += 2;
         if (rd_d != 32'(exp_d[a])) begin
            errors++;
            $display("FAIL %s data addr %0d: got %0d exp %0d", tag, a, rd_d, exp_d[a]);
         end
         if (rd_i != 32'(exp_i[a])) begin
            errors++;
            $display("FAIL %s instr addr %0d: got %0d exp %0d", tag, a, rd_i, exp_i[a]);
         end
      end
   endtask

   task automatic t_reset();
      zero_model();
      check_all("R1 reset");
   endtask

   task automatic t_reads();
      bsel = 2'd0;
      pulse(1, 0, 0, 0, 0, 0, 2'd0);
      pulse(0, 1, 0, 0, 1, 0, 2'd1);
      check_all("R2/R5/R7 reads");
   endtask

   task automatic t_bursts();
      bsel = 2'd1; pulse(0, 0, 0, 0, 1, 0, 2'd0);
      bsel = 2'd2; pulse(0, 0, 0, 0, 1, 0, 2'd0);
      bsel = 2'd3; pulse(0, 0, 0, 0, 1, 0, 2'd0);
      check_all("R3 burst cost");
   endtask

   task automatic t_writes();
      bsel = 2'd1;
      pulse(0, 0, 1, 0, 0, 0, 2'd2);
      pulse(0, 0, 0, 1, 1, 1, 2'd2);
      pulse(0, 0, 0, 0, 0, 1, 2'd1);
      check_all("R6/R8 writes");
   endtask

   task automatic t_combo();
      bsel = 2'd2;
      pulse(1, 1, 1, 1, 1, 1, 2'd1);
      check_all("R4 same-cycle");
   endtask

   task automatic t_oob();
      check_all("R10 readback");
   endtask

   task automatic t_saturate();
      for (int n = 0; n < 140; n++) pulse(1, 0, 1, 0, 0, 0, 2'd0);
      check_all("R9 saturation");
   endtask

   task automatic t_clear();
      @(negedge clk);
      clr = 1'b1; rh = 1; wm = 1; mr = 1; slot = 2'd2;
      @(negedge clk);
      clr = 1'b0; rh = 0; wm = 0; mr = 0;
      zero_model();
      check_all("R1 clear");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      zero_model();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_reads();
      t_bursts();
      t_writes();
      t_combo();
      t_oob();
      t_saturate();
      t_clear();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule